// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle it combines the working register value with either a register-file byte or an instruction literal, as a 4-bit opcode selects. It returns the result along with a strobe that says whether the result goes back to the working register or to the file register. All datapath logic is combinational. Only the five-bit status register is clocked.

The status register holds negative, signed overflow, zero, half-carry (carry out of the low nibble) and carry. It loads on a clock edge only when the update enable is high, and then only the flags that the current opcode is defined to touch. Add-with-carry and the two subtract-with-borrow opcodes take the stored carry as input, so software can chain bytes to build wider sums and differences. For every subtraction the carry is the inverted borrow.

Top module: `byte_alu`

## Requirements
- R1: Opcode 0 gives w_in + f_in. Opcode 1 gives w_in + f_in + C. Both update all five flags: N = result bit 7, Z = (result == 0), C = carry out of bit 7, DC = carry out of bit 3, OV = signed two's-complement overflow. Example: 0x4F + 0x48 gives 0x97 with N=1, OV=1, Z=0, DC=1, C=0.
- R2: Opcode 1 takes its carry-in from the stored C. An opcode 0 on the low bytes followed by an opcode 1 on the high bytes therefore yields a correct multi-byte sum.
- R3: Opcode 2 gives lit_in - w_in and opcode 3 gives f_in - w_in. Both update all five flags. C=1 means no borrow, and DC=1 means no borrow out of the low nibble.
- R4: Opcode 4 gives f_in - w_in - (not C) and opcode 5 gives w_in - f_in - (not C). Both update all five flags in the same way as R3.
- R5: Opcode 6 gives f_in + 1, opcode 7 gives f_in - 1 (C=1 when no borrow), and opcode 9 gives 0 - f_in. Each updates all five flags.
- R6: Opcode 8 gives the bitwise inverse of f_in, opcode 10 gives 0x00 and opcode 11 gives 0xFF. These three update only Z and N; OV, DC and C keep their values.
- R7: Opcode 12 exchanges the two nibbles of f_in. Opcode 14 passes lit_in. Neither changes any flag.
- R8: Opcode 13 passes f_in unchanged and updates only Z and N.
- R9: For every opcode except 2, 14 and 15, dest_sel=0 raises wr_w and dest_sel=1 raises wr_f. Opcodes 2 and 14 always raise wr_w and never wr_f. Opcode 15 raises neither strobe.
- R10: status is {N, OV, Z, DC, C}, bit 4 down to bit 0. It changes only on a rising clock edge with upd_en high. A synchronous active-high rst clears it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the status register |
| op | input | 4 | Operation code |
| w_in | input | 8 | Working register value |
| f_in | input | 8 | File register value |
| lit_in | input | 8 | Instruction literal |
| dest_sel | input | 1 | 0 = write result to working register, 1 = to file register |
| upd_en | input | 1 | Allow the status register to load this cycle |
| result | output | 8 | Operation result |
| wr_w | output | 1 | Result is destined for the working register |
| wr_f | output | 1 | Result is destined for the file register |
| status | output | 5 | Stored flags {N, OV, Z, DC, C} |

## Verification
The bench builds the block with its default data width of 8. This width makes every flag boundary reachable with byte operands: 0x7F/0x80 for signed overflow, 0xFF/0x00 for carry and borrow, and a low nibble of 0xF/0x0 for half-carry. Directed sequences cover these edges and two-byte carry chains. A sweep covering every opcode several times, with mixed destination and enable settings, catches flag masks that leak across opcodes.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

    localparam int FLAG_W = 5;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDC  = 4'd1,
        OP_LSUB  = 4'd2,
        OP_FSUB  = 4'd3,
        OP_FSUBB = 4'd4,
        OP_WSUBB = 4'd5,
        OP_INC   = 4'd6,
        OP_DEC   = 4'd7,
        OP_COMP  = 4'd8,
        OP_NEG   = 4'd9,
        OP_CLR   = 4'd10,
        OP_SETA  = 4'd11,
        OP_SWAP  = 4'd12,
        OP_MOVF  = 4'd13,
        OP_MOVL  = 4'd14,
        OP_RSVD  = 4'd15
    } alu_op_e;

    // packed MSB first: n is bit 4, c is bit 0
    typedef struct packed {
        logic n;
        logic ov;
        logic z;
        logic dc;
        logic c;
    } alu_flags_t;

    typedef enum logic [1:0] {
        SCOPE_NONE,
        SCOPE_ZN,
        SCOPE_ALL
    } flag_scope_e;

    function automatic flag_scope_e scope_of(alu_op_e o);
        case (o)
            OP_COMP, OP_CLR, OP_SETA, OP_MOVF: return SCOPE_ZN;
            OP_SWAP, OP_MOVL, OP_RSVD:        return SCOPE_NONE;
            default:                          return SCOPE_ALL;
        endcase
    endfunction

    function automatic alu_flags_t mask_of(flag_scope_e s);
        alu_flags_t m;
        m = '0;
        case (s)
            SCOPE_ALL: m = '1;
            SCOPE_ZN: begin
                m.n = 1'b1;
                m.z = 1'b1;
            end
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic logic uses_adder(alu_op_e o);
        case (o)
            OP_ADD, OP_ADDC, OP_LSUB, OP_FSUB, OP_FSUBB,
            OP_WSUBB, OP_INC, OP_DEC, OP_NEG: return 1'b1;
            default:                          return 1'b0;
        endcase
    endfunction

    function automatic logic is_literal(alu_op_e o);
        return (o == OP_LSUB) || (o == OP_MOVL);
    endfunction

endpackage

// File: rtl/alu_operand_mux.sv
module alu_operand_mux
    import byte_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] w_val,
    input  logic [DW-1:0] f_val,
    input  logic [DW-1:0] l_val,
    input  logic          c_flag,
    output logic [DW-1:0] a_opd,
    output logic [DW-1:0] b_opd,
    output logic          c_in
);
    // Subtraction x - y - borrow is formed as x + ~y + (not borrow)
    always_comb begin
        a_opd = f_val;
        b_opd = '0;
        c_in  = 1'b0;
        case (op)
            OP_ADD:   begin a_opd = w_val; b_opd = f_val;  c_in = 1'b0;   end
            OP_ADDC:  begin a_opd = w_val; b_opd = f_val;  c_in = c_flag; end
            OP_LSUB:  begin a_opd = l_val; b_opd = ~w_val; c_in = 1'b1;   end
            OP_FSUB:  begin a_opd = f_val; b_opd = ~w_val; c_in = 1'b1;   end
            OP_FSUBB: begin a_opd = f_val; b_opd = ~w_val; c_in = c_flag; end
            OP_WSUBB: begin a_opd = w_val; b_opd = ~f_val; c_in = c_flag; end
            OP_INC:   begin a_opd = f_val; b_opd = '0;     c_in = 1'b1;   end
            OP_DEC:   begin a_opd = f_val; b_opd = '1;     c_in = 1'b0;   end
            OP_NEG:   begin a_opd = '0;    b_opd = ~f_val; c_in = 1'b1;   end
            default:  begin a_opd = f_val; b_opd = '0;     c_in = 1'b0;   end
        endcase
    end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_opd,
    input  logic [DW-1:0] b_opd,
    input  logic          c_in,
    output logic [DW-1:0] sum,
    output logic          c_out,
    output logic          dc_out,
    output logic          ov_out
);
    localparam int NIB = DW / 2;
    localparam int HIW = DW - NIB;

    logic [NIB:0] lo_sum;
    logic [HIW:0] hi_sum;

    // split at the nibble boundary so the half-carry is a real carry wire
    assign lo_sum = {1'b0, a_opd[NIB-1:0]} + {1'b0, b_opd[NIB-1:0]}
                  + {{NIB{1'b0}}, c_in};
    assign hi_sum = {1'b0, a_opd[DW-1:NIB]} + {1'b0, b_opd[DW-1:NIB]}
                  + {{HIW{1'b0}}, lo_sum[NIB]};

    assign sum    = {hi_sum[HIW-1:0], lo_sum[NIB-1:0]};
    assign dc_out = lo_sum[NIB];
    assign c_out  = hi_sum[HIW];
    assign ov_out = (a_opd[DW-1] == b_opd[DW-1]) && (sum[DW-1] != a_opd[DW-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import byte_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] f_val,
    input  logic [DW-1:0] l_val,
    output logic [DW-1:0] l_res
);
    localparam int NIB = DW / 2;

    logic [DW-1:0] swapped;

    generate
        for (genvar i = 0; i < NIB; i++) begin : g_swap
            assign swapped[i]       = f_val[i+NIB];
            assign swapped[i+NIB]   = f_val[i];
        end
    endgenerate

    always_comb begin
        case (op)
            OP_COMP: l_res = ~f_val;
            OP_CLR:  l_res = '0;
            OP_SETA: l_res = '1;
            OP_SWAP: l_res = swapped;
            OP_MOVL: l_res = l_val;
            default: l_res = f_val;
        endcase
    end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
    import byte_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  logic [FLAG_W-1:0] mask,
    input  logic [FLAG_W-1:0] fresh,
    output logic [FLAG_W-1:0] status_q
);
    always_ff @(posedge clk) begin
        if (rst)
            status_q <= '0;
        else if (upd_en)
            status_q <= (status_q & ~mask) | (fresh & mask);
    end

    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> status_q == '0);

    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> status_q == $past(status_q));

    p_unmasked_kept_r6: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> ((status_q ^ $past(status_q)) & ~$past(mask)) == '0);
endmodule

// File: rtl/byte_alu.sv
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op,
    input  logic [DW-1:0]     w_in,
    input  logic [DW-1:0]     f_in,
    input  logic [DW-1:0]     lit_in,
    input  logic              dest_sel,
    input  logic              upd_en,
    output logic [DW-1:0]     result,
    output logic              wr_w,
    output logic              wr_f,
    output logic [FLAG_W-1:0] status
);
    alu_op_e       op_e;
    logic [DW-1:0] a_opd, b_opd, sum, l_res;
    logic          c_in, c_out, dc_out, ov_out;
    alu_flags_t    cur, fresh, mask;
    logic          lit_op, writes;

    assign op_e   = alu_op_e'(op);
    assign cur    = alu_flags_t'(status);
    assign lit_op = is_literal(op_e);
    assign writes = (op_e != OP_RSVD);

    alu_operand_mux #(.DW(DW)) u_opd (
        .op(op_e), .w_val(w_in), .f_val(f_in), .l_val(lit_in),
        .c_flag(cur.c), .a_opd(a_opd), .b_opd(b_opd), .c_in(c_in)
    );

    alu_adder #(.DW(DW)) u_add (
        .a_opd(a_opd), .b_opd(b_opd), .c_in(c_in),
        .sum(sum), .c_out(c_out), .dc_out(dc_out), .ov_out(ov_out)
    );

    alu_logic #(.DW(DW)) u_log (
        .op(op_e), .f_val(f_in), .l_val(lit_in), .l_res(l_res)
    );

    assign result = uses_adder(op_e) ? sum : l_res;

    always_comb begin
        fresh.n  = result[DW-1];
        fresh.z  = (result == '0);
        fresh.ov = ov_out;
        fresh.dc = dc_out;
        fresh.c  = c_out;
        mask     = mask_of(scope_of(op_e));
    end

    assign wr_w = writes && (lit_op || !dest_sel);
    assign wr_f = writes && !lit_op && dest_sel;

    alu_status_reg u_st (
        .clk(clk), .rst(rst), .upd_en(upd_en),
        .mask(mask), .fresh(fresh), .status_q(status)
    );

    p_lit_to_w_r9: assert property (@(posedge clk) disable iff (rst)
        (op_e == OP_LSUB || op_e == OP_MOVL) |-> (wr_w && !wr_f));

    p_clr_sets_z_r6: assert property (@(posedge clk) disable iff (rst)
        (op_e == OP_CLR && upd_en) |=> (status[2] && !status[4]));

    p_seta_ones_r6: assert property (@(posedge clk) disable iff (rst)
        (op_e == OP_SETA) |-> (result == '1));

    p_no_flag_move_r7: assert property (@(posedge clk) disable iff (rst)
        ((op_e == OP_SWAP || op_e == OP_MOVL) && upd_en) |=> $stable(status));

    p_z_tracks_r8: assert property (@(posedge clk) disable iff (rst)
        (upd_en && mask.z) |=> (status[2] == ($past(result) == '0)));
endmodule

// File: tb/sim_byte_alu.sv
module sim_byte_alu;

    typedef struct {
        logic       chk_res;
        logic [7:0] res;
        logic       ww;
        logic       wf;
        logic [4:0] st;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op = 4'd0;
    logic [7:0] w_in = '0, f_in = '0, lit_in = '0;
    logic       dest_sel = 1'b0, upd_en = 1'b0;
    logic [7:0] result;
    logic       wr_w, wr_f;
    logic [4:0] status;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    logic [4:0] sc = '0;
    exp_t q[$];

    always #4 clk = ~clk;

    byte_alu u0 (
        .clk(clk), .rst(rst), .op(op), .w_in(w_in), .f_in(f_in),
        .lit_in(lit_in), .dest_sel(dest_sel), .upd_en(upd_en),
        .result(result), .wr_w(wr_w), .wr_f(wr_f), .status(status)
    );

    // returns {result[7:0], ov, dc, c}
    function automatic logic [10:0] arith(input int x, input int y, input int k, input bit sub);
        int s, lo, sv, sx, sy;
        logic [7:0] r;
        sx = (x > 127) ? x - 256 : x;
        sy = (y > 127) ? y - 256 : y;
        if (!sub) begin
            s = x + y + k; lo = (x % 16) + (y % 16) + k; sv = sx + sy + k;
            r = s[7:0];
            return {r, (sv > 127 || sv < -128), (lo > 15), (s > 255)};
        end
        s = x - y - k; lo = (x % 16) - (y % 16) - k; sv = sx - sy - k;
        r = s[7:0];
        return {r, (sv > 127 || sv < -128), (lo >= 0), (s >= 0)};
    endfunction

    task automatic model(input logic [3:0] o, input logic [7:0] w, input logic [7:0] f,
                         input logic [7:0] l, input logic [4:0] st,
                         output logic [7:0] r, output logic [4:0] nf, output logic [4:0] m);
        logic [10:0] a;
        int c;
        c = int'(st[0]);
        a = '0;
        m = 5'b11111;
        r = f;
        case (o)
            4'd0:  a = arith(w, f, 0, 0);
            4'd1:  a = arith(w, f, c, 0);
            4'd2:  a = arith(l, w, 0, 1);
            4'd3:  a = arith(f, w, 0, 1);
            4'd4:  a = arith(f, w, 1 - c, 1);
            4'd5:  a = arith(w, f, 1 - c, 1);
            4'd6:  a = arith(f, 1, 0, 0);
            4'd7:  a = arith(f, 1, 0, 1);
            4'd9:  a = arith(0, f, 0, 1);
            4'd8:  begin r = ~f;    m = 5'b10100; end
            4'd10: begin r = 8'h00; m = 5'b10100; end
            4'd11: begin r = 8'hFF; m = 5'b10100; end
            4'd12: begin r = {f[3:0], f[7:4]}; m = 5'b00000; end
            4'd13: begin r = f;     m = 5'b10100; end
            4'd14: begin r = l;     m = 5'b00000; end
            default: begin r = f;   m = 5'b00000; end
        endcase
        if (m == 5'b11111) r = a[10:3];
        nf = {r[7], a[2], (r == 8'h00), a[1], a[0]};
    endtask

    task automatic drive(input logic [3:0] o, input logic [7:0] w, input logic [7:0] f,
                         input logic [7:0] l, input logic d, input logic en, input string tag);
        exp_t e;
        logic [7:0] r;
        logic [4:0] nf, m;
        @(negedge clk);
        op = o; w_in = w; f_in = f; lit_in = l; dest_sel = d; upd_en = en;
        model(o, w, f, l, sc, r, nf, m);
        e.chk_res = (o != 4'd15);
        e.res = r;
        e.ww  = (o != 4'd15) && ((o == 4'd2) || (o == 4'd14) || !d);
        e.wf  = (o != 4'd15) && !((o == 4'd2) || (o == 4'd14)) && d;
        if (en) sc = (sc & ~m) | (nf & m);
        e.st  = sc;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic check(input logic cond, input string tag, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // monitor: compares comb outputs mid low phase, status just after the edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                if (e.chk_res)
                    check(result === e.res, e.tag, "result", int'(result), int'(e.res));
                check({wr_w, wr_f} === {e.ww, e.wf}, e.tag, "wr_w/wr_f",
                      int'({wr_w, wr_f}), int'({e.ww, e.wf}));
                @(posedge clk);
                #1;
                check(status === e.st, e.tag, "status", int'(status), int'(e.st));
            end
        end
    end

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1; upd_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        sc = '0;
        check(status === 5'b00000, "R10 reset", "status", int'(status), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(status === 5'b00000, "R10 reset state", "status", int'(status), 0);

        drive(4'd0, 8'h4F, 8'h48, 8'h00, 1'b0, 1'b1, "R1 add example");
        drive(4'd0, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b1, "R1 add wrap zero");
        drive(4'd0, 8'h92, 8'h91, 8'h00, 1'b0, 1'b1, "R2 low byte add");
        drive(4'd1, 8'h72, 8'h1F, 8'h00, 1'b0, 1'b1, "R2 high byte addc C=1");
        drive(4'd0, 8'h01, 8'h01, 8'h00, 1'b0, 1'b1, "R2 clear carry");
        drive(4'd1, 8'h10, 8'h20, 8'h00, 1'b1, 1'b1, "R2 addc C=0");
        drive(4'd2, 8'h07, 8'h00, 8'h05, 1'b0, 1'b1, "R3 lit sub borrow");
        drive(4'd2, 8'h22, 8'h00, 8'hA2, 1'b1, 1'b1, "R3 R9 lit sub dest ignored");
        drive(4'd3, 8'h7F, 8'h28, 8'h00, 1'b0, 1'b1, "R3 file sub");
        drive(4'd3, 8'h01, 8'h80, 8'h00, 1'b1, 1'b1, "R3 file sub overflow");
        drive(4'd3, 8'h05, 8'h05, 8'h00, 1'b0, 1'b1, "R3 file sub equal");
        drive(4'd3, 8'h02, 8'h01, 8'h00, 1'b0, 1'b1, "R4 make borrow");
        drive(4'd4, 8'h05, 8'h10, 8'h00, 1'b0, 1'b1, "R4 fsubb borrow in");
        drive(4'd5, 8'h50, 8'h20, 8'h00, 1'b1, 1'b1, "R4 wsubb no borrow");
        drive(4'd5, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, "R4 wsubb zero");
        drive(4'd6, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b1, "R5 inc wrap");
        drive(4'd6, 8'h00, 8'h7F, 8'h00, 1'b1, 1'b1, "R5 inc overflow");
        drive(4'd7, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, "R5 dec borrow");
        drive(4'd7, 8'h00, 8'h80, 8'h00, 1'b0, 1'b1, "R5 dec overflow");
        drive(4'd9, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, "R5 neg zero");
        drive(4'd9, 8'h00, 8'h80, 8'h00, 1'b1, 1'b1, "R5 neg min");
        drive(4'd9, 8'h00, 8'h01, 8'h00, 1'b1, 1'b1, "R5 neg one");
        drive(4'd6, 8'h00, 8'h7F, 8'h00, 1'b1, 1'b1, "R6 preset flags");
        drive(4'd8, 8'h00, 8'h55, 8'h00, 1'b0, 1'b1, "R6 complement");
        drive(4'd10, 8'h00, 8'h9C, 8'h00, 1'b1, 1'b1, "R6 clear");
        drive(4'd11, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, "R6 set all");
        drive(4'd12, 8'h00, 8'hA5, 8'h00, 1'b1, 1'b1, "R7 swap");
        drive(4'd14, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, "R7 R9 literal move");
        drive(4'd13, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, "R8 move zero");
        drive(4'd13, 8'h00, 8'hC3, 8'h00, 1'b0, 1'b1, "R8 move negative");
        drive(4'd15, 8'h11, 8'h22, 8'h33, 1'b1, 1'b1, "R9 reserved");
        drive(4'd0, 8'h80, 8'h80, 8'h00, 1'b0, 1'b0, "R10 enable low");
        drive(4'd0, 8'h80, 8'h80, 8'h00, 1'b0, 1'b1, "R10 enable high");
        do_reset();

        for (int i = 0; i < 64; i++) begin
            int wv, fv, lv;
            wv = (i * 37 + 11) % 256;
            fv = (i * 73 + 5) % 256;
            lv = (i * 29) % 256;
            drive(4'(i % 16), 8'(wv), 8'(fv), 8'(lv), 1'(i % 2), (i % 5) != 4,
                  "R1 R4 R6 R9 sweep");
        end

        @(negedge clk);
        upd_en = 1'b0;
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule